// File: doc/BRIEF.md
# Asynchronous nvSRAM Byte Bus Controller

This block sits between an on-chip requester and an external 32K x 8 asynchronous static RAM with a nonvolatile shadow. The requester offers one byte access at a time over a valid/ready handshake: a 15-bit address, a write flag and a write byte. The controller turns each accepted request into a strobe sequence on the memory pins. It drives active-low chip enable, write enable and output enable, holds the address steady, and runs the write-data driver through a separate output-enable line. A read returns its byte with a one-cycle response pulse.

Every minimum time is a parameter counted in clock cycles. `WR_PULSE` sets the write strobe width, `RD_CYC` sets the read strobe window, and `TURN_GAP` sets the extra idle cycles inserted when the access direction changes. The memory's active-low store-busy line is synchronised. While it is low, no new request is taken and no strobe falls. All strobes and the driver enable come straight from flops, so the pins do not glitch.

The sequencer has six states:
- IDLE: ready when not busy; accepting a request moves to GAP if the direction differs from the previous access, otherwise to SETUP.
- GAP: all strobes inactive for `TURN_GAP` cycles, then moves to SETUP.
- SETUP: address presented with strobes inactive; it waits while busy, then moves to WRITE or READ.
- WRITE: chip enable and write enable low with the driver on for `WR_PULSE` cycles, then moves to DONE.
- READ: chip enable and output enable low for `RD_CYC` cycles; the data is captured on the final edge, then moves to DONE.
- DONE: strobes inactive, and the response pulse is high after a read; then back to IDLE.

Top module: `nvsram_bus_ctrl`

## Requirements
- R1: While reset is held, mem_ce_n, mem_we_n and mem_oe_n are 1, and mem_dq_oe, rsp_valid and req_ready are 0.
- R2: req_ready is 1 only when the sequencer is idle and the synchronised store-busy line is high. It is 0 from the cycle after acceptance until the access has completed. It is never 1 while mem_ce_n is 0.
- R3: While mem_busy_n is low, no request is accepted and mem_ce_n stays 1. Once mem_busy_n returns high, a pending request proceeds.
- R4: A write holds mem_ce_n and mem_we_n low together for exactly WR_PULSE cycles, with mem_oe_n at 1. mem_dq_oe is 1 in exactly those cycles, carrying the request's byte. Both strobes rise on the same edge.
- R5: A read holds mem_ce_n and mem_oe_n low for exactly RD_CYC cycles, with mem_we_n at 1 and mem_dq_oe at 0. The byte present on mem_dq_in during the last of those cycles is returned on rsp_rdata. rsp_valid is 1 for exactly the one cycle that follows the strobe window.
- R6: mem_addr does not change in any cycle in which mem_ce_n was 0 in the previous cycle and is still 0.
- R7: Between the end of one access strobe and the start of the next, mem_ce_n stays 1 for at least TURN_GAP+3 cycles if the direction changes, and for at least 3 cycles otherwise.
- R8: rsp_valid is never 1 except in the cycle directly after a read strobe window; writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: read byte valid |
| rsp_rdata | output | 8 | Read byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Tri-state enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from the memory |
| mem_busy_n | input | 1 | Store busy from the memory, active low |

## Verification
The bench builds the controller with WR_PULSE=3, RD_CYC=4 and TURN_GAP=2. Because the read window differs from its default, a hard-coded window length would show up as a pulse-width mismatch. Keeping the two strobe widths unequal also lets the monitor tell reads from writes by length alone. With TURN_GAP at 2, the direction-change spacing of at least 5 inactive cycles stands apart from the same-direction minimum of 3, so a missing GAP state can be seen. The memory model returns address-dependent bytes, which puts the lowest address, the highest address and never-written locations in reach.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GAP   = 3'd1,
        ST_SETUP = 3'd2,
        ST_WRITE = 3'd3,
        ST_READ  = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    function automatic pin_ctl_t pins_for(input seq_state_t s);
        pin_ctl_t p;
        p = PINS_QUIET;
        if (s == ST_WRITE) begin
            p.ce_n  = 1'b0;
            p.we_n  = 1'b0;
            p.drive = 1'b1;
        end else if (s == ST_READ) begin
            p.ce_n = 1'b0;
            p.oe_n = 1'b0;
        end
        return p;
    endfunction

endpackage

// File: rtl/nvsram_busy_sync.sv
module nvsram_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_n_async,
    output logic not_busy
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= busy_n_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], busy_n_async};
            end
        end
    endgenerate

    assign not_busy = chain_q[STAGES-1];
endmodule

// File: rtl/nvsram_cycle_timer.sv
module nvsram_cycle_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= len - CNT_W'(1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvsram_seq_fsm.sv
module nvsram_seq_fsm
    import nvsram_pkg::*;
#(
    parameter int WR_PULSE = 3,
    parameter int RD_CYC   = 5,
    parameter int TURN_GAP = 2,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             not_busy,
    input  logic             expired,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             timer_start,
    output logic [CNT_W-1:0] timer_len,
    output pin_ctl_t         pins,
    output logic             rsp_valid
);
    localparam logic [CNT_W-1:0] WR_LEN  = CNT_W'(WR_PULSE);
    localparam logic [CNT_W-1:0] RD_LEN  = CNT_W'(RD_CYC);
    localparam logic [CNT_W-1:0] GAP_LEN = CNT_W'(TURN_GAP);

    seq_state_t state_q, state_nx;
    logic       have_prev_q;
    logic       is_write_q;
    logic       need_gap;

    assign req_ready = (state_q == ST_IDLE) && not_busy;
    assign accept    = req_ready && req_valid;
    assign need_gap  = have_prev_q && (is_write_q != req_write);
    assign capture   = (state_q == ST_READ) && expired;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)   state_nx = need_gap ? ST_GAP : ST_SETUP;
            ST_GAP:   if (expired)  state_nx = ST_SETUP;
            ST_SETUP: if (not_busy) state_nx = is_write_q ? ST_WRITE : ST_READ;
            ST_WRITE: if (expired)  state_nx = ST_DONE;
            ST_READ:  if (expired)  state_nx = ST_DONE;
            ST_DONE:                state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        timer_start = (state_nx != state_q) &&
                      (state_nx == ST_GAP || state_nx == ST_WRITE || state_nx == ST_READ);
        unique case (state_nx)
            ST_WRITE: timer_len = WR_LEN;
            ST_READ:  timer_len = RD_LEN;
            default:  timer_len = GAP_LEN;
        endcase
    end

    // State register and direction memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            have_prev_q <= 1'b0;
            is_write_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (accept) begin
                have_prev_q <= 1'b1;
                is_write_q  <= req_write;
            end
        end
    end

    // Registered pin outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins      <= PINS_QUIET;
            rsp_valid <= 1'b0;
        end else begin
            pins      <= pins_for(state_nx);
            rsp_valid <= capture;
        end
    end

    // R4
    we_rise_with_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins.we_n) |-> $rose(pins.ce_n));

    // R4
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pins.we_n == 1'b0 && pins.oe_n == 1'b0));
endmodule

// File: rtl/nvsram_bus_ctrl.sv
module nvsram_bus_ctrl
    import nvsram_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int WR_PULSE    = 3,
    parameter int RD_CYC      = 5,
    parameter int TURN_GAP    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    input  logic              mem_busy_n
);
    localparam int MAX_LEN = (WR_PULSE > RD_CYC) ?
                             ((WR_PULSE > TURN_GAP) ? WR_PULSE : TURN_GAP) :
                             ((RD_CYC > TURN_GAP) ? RD_CYC : TURN_GAP);
    localparam int CNT_W = $clog2(MAX_LEN + 1);

    logic             not_busy;
    logic             expired;
    logic             accept;
    logic             capture;
    logic             timer_start;
    logic [CNT_W-1:0] timer_len;
    pin_ctl_t         pins;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    nvsram_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_n_async (mem_busy_n),
        .not_busy     (not_busy)
    );

    nvsram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (timer_start),
        .len     (timer_len),
        .expired (expired)
    );

    nvsram_seq_fsm #(
        .WR_PULSE (WR_PULSE),
        .RD_CYC   (RD_CYC),
        .TURN_GAP (TURN_GAP),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .not_busy    (not_busy),
        .expired     (expired),
        .req_ready   (req_ready),
        .accept      (accept),
        .capture     (capture),
        .timer_start (timer_start),
        .timer_len   (timer_len),
        .pins        (pins),
        .rsp_valid   (rsp_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (capture) rdata_q <= mem_dq_in;
        end
    end

    assign mem_ce_n   = pins.ce_n;
    assign mem_we_n   = pins.we_n;
    assign mem_oe_n   = pins.oe_n;
    assign mem_dq_oe  = pins.drive;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_rdata  = rdata_q;

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R3
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> $past(not_busy));

    // R2
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && not_busy));

    // R5
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R8
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));
endmodule

// File: tb/nvsram_bus_ctrl_test.sv
module nvsram_bus_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WRP = 3;
    localparam int RDC = 4;
    localparam int TGP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in = 8'hEE;
    logic        mem_busy_n = 1'b1;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [7:0] model_mem [int];
    logic [7:0] shadow [int];
    logic [7:0] expq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvsram_bus_ctrl #(
        .WR_PULSE (WRP),
        .RD_CYC   (RDC),
        .TURN_GAP (TGP)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_busy_n(mem_busy_n)
    );

    function automatic logic [7:0] init_byte(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Driver: offer a request, wait for acceptance, push expectations
    task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (w) shadow[int'(a)] = d;
        else   expq.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : init_byte(a));
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    endtask

    // Monitor and memory model
    bit         p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b1;
    logic [14:0] p_addr = '0;
    logic [7:0]  p_dq = '0;
    int          runlen = 0;
    int          inact = 0;
    bit          have_prev = 1'b0;
    bit          prev_dir_w = 1'b0;
    bit          cur_dir_w = 1'b0;
    bit          read_just_ended = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            read_just_ended = 1'b0;
            if (!p_ce && mem_ce_n) begin
                if (cur_dir_w) begin
                    chk(runlen == WRP, "R4 write pulse width", runlen, WRP);
                    chk(mem_we_n == 1'b1, "R4 we rises with ce", mem_we_n, 1);
                    model_mem[int'(p_addr)] = p_dq;
                end else begin
                    chk(runlen == RDC, "R5 read window width", runlen, RDC);
                    chk(rsp_valid == 1'b1, "R5 response follows window", rsp_valid, 1);
                    read_just_ended = 1'b1;
                end
                have_prev = 1'b1;
                prev_dir_w = cur_dir_w;
                inact = 0;
            end
            if (p_ce && !mem_ce_n) begin
                cur_dir_w = !mem_we_n;
                runlen = 0;
                if (have_prev) begin
                    if (cur_dir_w != prev_dir_w)
                        chk(inact >= TGP + 3, "R7 turnaround spacing", inact, TGP + 3);
                    else
                        chk(inact >= 3, "R7 same-direction spacing", inact, 3);
                end
            end
            if (!mem_ce_n) begin
                runlen++;
                if (!p_ce) begin
                    if (mem_addr != p_addr) chk(1'b0, "R6 address held", mem_addr, p_addr);
                end
                if (req_ready) chk(1'b0, "R2 ready during access", req_ready, 0);
                if (cur_dir_w) begin
                    if (!(mem_dq_oe && !mem_we_n && mem_oe_n))
                        chk(1'b0, "R4 write strobes and driver", {mem_dq_oe, mem_we_n, mem_oe_n}, 3'b100);
                end else begin
                    if (!(!mem_dq_oe && mem_we_n && !mem_oe_n))
                        chk(1'b0, "R5 read strobes", {mem_dq_oe, mem_we_n, mem_oe_n}, 3'b010);
                end
            end else begin
                inact++;
                if (mem_dq_oe) chk(1'b0, "R4 driver off outside write", mem_dq_oe, 0);
            end
            if (rsp_valid) begin
                if (!read_just_ended) chk(1'b0, "R8 stray response", rsp_valid, 0);
                if (expq.size() == 0) chk(1'b0, "R8 unexpected response", rsp_valid, 0);
                else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    chk(rsp_rdata == e, "R5 read data", rsp_rdata, e);
                end
            end
            p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_oe_n;
            p_addr = mem_addr; p_dq = mem_dq_out;
            if (!mem_ce_n && !mem_oe_n)
                mem_dq_in = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)]
                                                              : init_byte(mem_addr);
            else
                mem_dq_in = 8'hEE;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            report();
        end
    end

    initial begin
        repeat (3) begin
            @(negedge clk);
            chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes idle in reset",
                {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
            chk(!mem_dq_oe && !rsp_valid && !req_ready, "R1 outputs low in reset",
                {mem_dq_oe, rsp_valid, req_ready}, 0);
        end
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready when idle and not busy", req_ready, 1);

        issue(1'b1, 15'h0000, 8'hA5);
        issue(1'b1, 15'h7FFF, 8'h3C);
        issue(1'b1, 15'h1234, 8'h99);
        issue(1'b0, 15'h0000, 8'h00);
        issue(1'b0, 15'h7FFF, 8'h00);
        issue(1'b0, 15'h1234, 8'h00);
        issue(1'b0, 15'h0042, 8'h00);
        issue(1'b1, 15'h1234, 8'h11);
        issue(1'b0, 15'h1234, 8'h00);
        issue(1'b1, 15'h2000, 8'hF0);
        issue(1'b0, 15'h2000, 8'h00);

        // R3: store busy holds everything off
        repeat (4) @(negedge clk);
        mem_busy_n = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h7FFF;
        repeat (8) begin
            @(negedge clk);
            chk(!req_ready && mem_ce_n, "R3 held off while busy",
                {req_ready, mem_ce_n}, 2'b01);
        end
        mem_busy_n = 1'b1;
        while (!req_ready) @(negedge clk);
        expq.push_back(shadow[int'(15'h7FFF)]);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R3 proceeds after busy released", req_ready, 0);

        issue(1'b1, 15'h0001, 8'h5F);
        issue(1'b0, 15'h0001, 8'h00);

        while (expq.size() != 0 || !req_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R8 all reads answered", expq.size(), 0);
        report();
    end
endmodule